// File: doc/BRIEF.md
# Clock Fail and Frequency Monitor

This block guards the main system clock of a chip. An independent backup oscillator, which must run faster than the system clock, clocks a loss detector. A toggle flop in the system domain changes level on every system edge. The detector synchronises that toggle and counts backup cycles in which it does not move. When the count reaches a limit, the system clock is declared lost. A trap line is raised and a switching state machine moves the clock output from the system clock to the backup clock without glitches. The switch stays in effect until the next reset.

A second part, clocked by the system clock, counts system clock edges between rising edges of a reference tick. The tick can come from a secondary oscillator or a line-frequency pulse. It compares each finished count against a lower and an upper limit and raises a too-slow or a too-fast flag. In event mode the same window counts rising edges of an event input, such as an interrupt line, so that an event rate can be held inside a programmed range.

The loss state machine has four states:
- `LS_RUN`: the system clock is selected. It moves to `LS_DROP` when the quiet count completes.
- `LS_DROP`: the old gate is asked to close on its own falling edge. It moves to `LS_ARM` when the closed gate is seen, or when a timeout expires and the gate is forced shut.
- `LS_ARM`: the backup gate opens on a backup falling edge. It moves to `LS_BACKUP` unconditionally.
- `LS_BACKUP`: terminal until reset.

The window state machine has two states:
- `WS_IDLE`: entered at reset. It waits for the first reference edge and then moves to `WS_COUNT`.
- `WS_COUNT`: evaluates a window at every later reference edge.

Top module: `clkmon_guard`

## Requirements
- R1: While reset is asserted `clk_o` is low and `clk_fail_o`, `too_fast_o`, `too_slow_o` and `win_count_o` are zero. After reset, with the system clock running, `clk_o` carries one rising edge per system clock cycle and `clk_fail_o` stays low.
- R2: The system clock is declared lost only after LOSS_CYCLES (default 4) consecutive backup cycles in which no toggle of the synchronised system-domain flop is seen. At that point `clk_fail_o` is raised.
- R3: After a loss, `clk_o` carries one rising edge per backup clock cycle. `clk_fail_o` and the backup selection hold until reset, even if the system clock resumes.
- R4: The system gate is closed before the backup gate opens. No high or low phase of `clk_o` is shorter than the shorter half-period of the two clocks.
- R5: If the stopped system clock gives no falling edge, its gate is forced shut after DROP_WAIT (default 8) backup cycles in `LS_DROP`. This holds also when the clock is stuck high.
- R6: With `evt_mode_i`=0, `win_count_o` takes, at each reference rising edge, the number of system clock cycles since the previous reference rising edge. It does not change between those edges.
- R7: A finished count greater than `lim_hi_i` sets `too_fast_o`.
- R8: A finished count less than `lim_lo_i` sets `too_slow_o`. A count equal to a limit sets neither flag.
- R9: With `evt_mode_i`=1, the finished count is the number of rising edges of `evt_i` inside the window.
- R10: Both range flags are sticky. A one-cycle high on `flag_clr_i` clears them, except that a violation found in the same cycle sets its flag.
- R11: The first reference edge after reset only opens a window. No count and no flag is produced by it.
- R12: The window count saturates at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk_i | input | 1 | Monitored system clock |
| bak_clk_i | input | 1 | Backup oscillator, free running, faster than the system clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Reference timebase; its rising edges bound the windows |
| evt_i | input | 1 | Event line counted in event mode |
| evt_mode_i | input | 1 | 0: count system clock cycles, 1: count event edges |
| lim_lo_i | input | 16 | Lower count limit |
| lim_hi_i | input | 16 | Upper count limit |
| flag_clr_i | input | 1 | Clears the sticky range flags (system domain) |
| clk_o | output | 1 | Glitch-free selected clock |
| clk_fail_o | output | 1 | Clock loss trap / non-maskable interrupt request |
| too_fast_o | output | 1 | Sticky count-above-range flag |
| too_slow_o | output | 1 | Sticky count-below-range flag |
| win_count_o | output | 16 | Count of the last finished window |

## Verification
The window checker is driven with directed windows first:
- a window that is only opened after reset;
- counts above, below and exactly on each limit;
- event bursts under, inside and over the range;
- one window longer than the counter can hold.

These separate the fast, slow and boundary decisions, as well as saturation. Seeded random windows then mix the window length, the mode, the event count, the limits and the clear pulses. Each result is checked against a count and sticky flags computed in the bench. The loss path is tried once with the system clock stopped low, which closes the gate through the falling-edge handshake timeout. It is tried again with the clock stuck high, which needs the forced close. In both cases the bench counts output edges before and after the switch and measures the shortest pulse. A restart of the system clock shows that the failover holds.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;

    typedef enum logic [1:0] {
        LS_RUN    = 2'd0,
        LS_DROP   = 2'd1,
        LS_ARM    = 2'd2,
        LS_BACKUP = 2'd3
    } loss_st_t;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_COUNT = 1'b1
    } win_st_t;

endpackage

// File: rtl/clkmon_loss.sv
`timescale 1ns/1ps
module clkmon_loss
    import clkmon_pkg::*;
#(
    parameter int LOSS_CYCLES = 4,
    parameter int DROP_WAIT   = 8
) (
    input  logic sys_clk_i,
    input  logic bak_clk_i,
    input  logic rst_n_i,
    input  logic sys_en_i,
    output logic req_off_o,
    output logic force_off_o,
    output logic arm_o,
    output logic fail_o
);

    localparam int SW = $clog2(LOSS_CYCLES + 1);
    localparam int DW = $clog2(DROP_WAIT + 1);

    logic          heart_q;
    logic [2:0]    heart_sh;
    logic [1:0]    ack_sh;
    logic          tog_edge;
    logic          lost;
    logic [SW-1:0] quiet_q;
    logic [DW-1:0] drop_cnt;
    logic          drop_done;
    loss_st_t      state_q, state_d;

    // system-domain heartbeat: flips on every system edge
    always_ff @(posedge sys_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) heart_q <= 1'b0;
        else          heart_q <= ~heart_q;
    end

    always_ff @(posedge bak_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            heart_sh <= '0;
            ack_sh   <= '0;
        end else begin
            heart_sh <= {heart_sh[1:0], heart_q};
            ack_sh   <= {ack_sh[0], sys_en_i};
        end
    end

    assign tog_edge = heart_sh[2] ^ heart_sh[1];
    assign lost     = !tog_edge && (quiet_q == SW'(LOSS_CYCLES - 1));

    always_ff @(posedge bak_clk_i or negedge rst_n_i) begin
        if (!rst_n_i)                          quiet_q <= '0;
        else if (tog_edge)                     quiet_q <= '0;
        else if (quiet_q != SW'(LOSS_CYCLES))  quiet_q <= quiet_q + 1'b1;
    end

    assign drop_done = (drop_cnt == DW'(DROP_WAIT));

    // state register
    always_ff @(posedge bak_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= LS_RUN;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_RUN:    if (lost) state_d = LS_DROP;
            LS_DROP:   if (!ack_sh[1] || drop_done) state_d = LS_ARM;
            LS_ARM:    state_d = LS_BACKUP;
            LS_BACKUP: state_d = LS_BACKUP;
            default:   state_d = LS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        req_off_o = (state_q != LS_RUN);
        arm_o     = (state_q == LS_ARM) || (state_q == LS_BACKUP);
        fail_o    = (state_q != LS_RUN);
    end

    always_ff @(posedge bak_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            drop_cnt    <= '0;
            force_off_o <= 1'b0;
        end else if (state_q == LS_DROP) begin
            if (!drop_done) drop_cnt <= drop_cnt + 1'b1;
            if (drop_done && ack_sh[1]) force_off_o <= 1'b1;
        end
    end

    // a seen heartbeat keeps the monitor in the running state
    assert_beat_keeps_run_R2: assert property (@(posedge bak_clk_i) disable iff (!rst_n_i)
        (state_q == LS_RUN && tog_edge) |=> (state_q == LS_RUN));

    assert_failover_holds_R3: assert property (@(posedge bak_clk_i) disable iff (!rst_n_i)
        (state_q == LS_BACKUP) |=> (fail_o && arm_o));

endmodule

// File: rtl/clkmon_switch.sv
`timescale 1ns/1ps
module clkmon_switch (
    input  logic sys_clk_i,
    input  logic bak_clk_i,
    input  logic rst_n_i,
    input  logic req_off_i,
    input  logic force_off_i,
    input  logic arm_i,
    output logic sys_en_o,
    output logic clk_o
);

    logic [1:0] req_sh;
    logic       sys_kill;
    logic       bak_en_q;

    assign sys_kill = !rst_n_i || force_off_i;

    // system gate: changes only on the system falling edge, or is forced shut
    always_ff @(negedge sys_clk_i or posedge sys_kill) begin
        if (sys_kill) begin
            req_sh   <= '0;
            sys_en_o <= 1'b0;
        end else begin
            req_sh   <= {req_sh[0], req_off_i};
            sys_en_o <= ~req_sh[1];
        end
    end

    // backup gate: opens on a backup falling edge
    always_ff @(negedge bak_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) bak_en_q <= 1'b0;
        else          bak_en_q <= arm_i;
    end

    assign clk_o = (sys_clk_i & sys_en_o) | (bak_clk_i & bak_en_q);

    assert_gates_exclusive_R4: assert property (@(posedge bak_clk_i) disable iff (!rst_n_i)
        !(sys_en_o && bak_en_q));

endmodule

// File: rtl/clkmon_window.sv
`timescale 1ns/1ps
module clkmon_window
    import clkmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             ref_i,
    input  logic             evt_i,
    input  logic             evt_mode_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             fast_o,
    output logic             slow_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]       ref_sh, evt_sh;
    logic             ref_rise, evt_rise, inc;
    logic             upd, fast_set, slow_set;
    logic [CNT_W-1:0] cnt_q;
    win_st_t          state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ref_sh <= '0;
            evt_sh <= '0;
        end else begin
            ref_sh <= {ref_sh[1:0], ref_i};
            evt_sh <= {evt_sh[1:0], evt_i};
        end
    end

    assign ref_rise = ref_sh[1] & ~ref_sh[2];
    assign evt_rise = evt_sh[1] & ~evt_sh[2];
    assign inc      = evt_mode_i ? evt_rise : 1'b1;

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= WS_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (ref_rise) state_d = WS_COUNT;
            WS_COUNT: state_d = WS_COUNT;
            default:  state_d = WS_IDLE;
        endcase
    end

    assign upd      = ref_rise && (state_q == WS_COUNT);
    assign fast_set = upd && (cnt_q > lim_hi_i);
    assign slow_set = upd && (cnt_q < lim_lo_i);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)                                   cnt_q <= '0;
        else if (ref_rise)                              cnt_q <= CNT_W'(inc);
        else if (state_q == WS_COUNT && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(inc);
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            meas_o <= '0;
            fast_o <= 1'b0;
            slow_o <= 1'b0;
        end else begin
            if (upd) meas_o <= cnt_q;
            fast_o <= fast_set | (fast_o & ~clr_i);
            slow_o <= slow_set | (slow_o & ~clr_i);
        end
    end

    assert_count_held_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !upd |=> $stable(meas_o));

    assert_flags_disjoint_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (lim_lo_i <= lim_hi_i) |-> !(fast_set && slow_set));

    assert_clear_works_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_i && !upd) |=> (!fast_o && !slow_o));

    assert_first_edge_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == WS_IDLE) |-> (meas_o == '0 && !fast_o && !slow_o));

endmodule

// File: rtl/clkmon_guard.sv
`timescale 1ns/1ps
module clkmon_guard #(
    parameter int LOSS_CYCLES = 4,
    parameter int DROP_WAIT   = 8,
    parameter int CNT_W       = 16
) (
    input  logic             sys_clk_i,
    input  logic             bak_clk_i,
    input  logic             rst_n_i,
    input  logic             ref_tick_i,
    input  logic             evt_i,
    input  logic             evt_mode_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    input  logic             flag_clr_i,
    output logic             clk_o,
    output logic             clk_fail_o,
    output logic             too_fast_o,
    output logic             too_slow_o,
    output logic [CNT_W-1:0] win_count_o
);

    logic sys_en;
    logic req_off;
    logic force_off;
    logic arm;

    clkmon_loss #(
        .LOSS_CYCLES (LOSS_CYCLES),
        .DROP_WAIT   (DROP_WAIT)
    ) u_loss (
        .sys_clk_i   (sys_clk_i),
        .bak_clk_i   (bak_clk_i),
        .rst_n_i     (rst_n_i),
        .sys_en_i    (sys_en),
        .req_off_o   (req_off),
        .force_off_o (force_off),
        .arm_o       (arm),
        .fail_o      (clk_fail_o)
    );

    clkmon_switch u_switch (
        .sys_clk_i   (sys_clk_i),
        .bak_clk_i   (bak_clk_i),
        .rst_n_i     (rst_n_i),
        .req_off_i   (req_off),
        .force_off_i (force_off),
        .arm_i       (arm),
        .sys_en_o    (sys_en),
        .clk_o       (clk_o)
    );

    clkmon_window #(
        .CNT_W (CNT_W)
    ) u_window (
        .clk_i      (sys_clk_i),
        .rst_n_i    (rst_n_i),
        .ref_i      (ref_tick_i),
        .evt_i      (evt_i),
        .evt_mode_i (evt_mode_i),
        .lim_lo_i   (lim_lo_i),
        .lim_hi_i   (lim_hi_i),
        .clr_i      (flag_clr_i),
        .meas_o     (win_count_o),
        .fast_o     (too_fast_o),
        .slow_o     (too_slow_o)
    );

endmodule

// File: tb/tb_clkmon_guard.sv
`timescale 1ns/1ps
module tb_clkmon_guard;

    logic        sys_clk = 1'b0;
    logic        bak_clk = 1'b0;
    logic        sys_run = 1'b1;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        evt = 1'b0;
    logic        evt_mode = 1'b0;
    logic [15:0] lim_lo = 16'h0000;
    logic [15:0] lim_hi = 16'hFFFF;
    logic        flag_clr = 1'b0;
    logic        clk_o;
    logic        clk_fail;
    logic        too_fast;
    logic        too_slow;
    logic [15:0] win_count;

    int n_run = 0;
    int n_fail = 0;

    // 50 MHz system clock, stoppable; backup clock with a 14 ns period
    always begin
        #10;
        if (sys_run) sys_clk = ~sys_clk;
    end
    always #7 bak_clk = ~bak_clk;

    clkmon_guard dut (
        .sys_clk_i   (sys_clk),
        .bak_clk_i   (bak_clk),
        .rst_n_i     (rst_n),
        .ref_tick_i  (ref_tick),
        .evt_i       (evt),
        .evt_mode_i  (evt_mode),
        .lim_lo_i    (lim_lo),
        .lim_hi_i    (lim_hi),
        .flag_clr_i  (flag_clr),
        .clk_o       (clk_o),
        .clk_fail_o  (clk_fail),
        .too_fast_o  (too_fast),
        .too_slow_o  (too_slow),
        .win_count_o (win_count)
    );

    int  clk_edges = 0;
    real last_t = 0.0;
    real min_w = 1.0e9;
    bit  pw_en = 1'b0;

    always @(posedge clk_o) clk_edges++;
    always @(clk_o) begin
        if (pw_en && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
        last_t = $realtime;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expectation model for the window checker
    bit          prev_valid = 1'b0;
    int          prev_exp = 0;
    string       prev_tag = "R6";
    logic [15:0] prev_lo = 16'h0000;
    logic [15:0] prev_hi = 16'hFFFF;
    bit          exp_fast = 1'b0;
    bit          exp_slow = 1'b0;

    function automatic int clamp16(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic check_prev();
        if (!prev_valid) begin
            chk("R11 count", 32'(win_count), 32'd0);
            chk("R11 flags", {30'd0, too_fast, too_slow}, 32'd0);
        end else begin
            if (prev_exp > int'(prev_hi)) exp_fast = 1'b1;
            if (prev_exp < int'(prev_lo)) exp_slow = 1'b1;
            chk(prev_tag, 32'(win_count), 32'(prev_exp));
            chk("R7 too_fast", 32'(too_fast), 32'(exp_fast));
            chk("R8 too_slow", 32'(too_slow), 32'(exp_slow));
        end
    endtask

    task automatic run_window(input int p, input int nev, input bit mode,
                              input logic [15:0] lo, input logic [15:0] hi, input bit do_clr);
        for (int j = 0; j < p; j++) begin
            @(negedge sys_clk);
            ref_tick = (j < 2);
            evt = mode && (j >= 2) && (((j - 2) % 4) < 2) && (((j - 2) / 4) < nev);
            if (j == 2) evt_mode = mode;
            if (j == 5) check_prev();
            if (j == 10) begin
                lim_lo = lo;
                lim_hi = hi;
                if (do_clr) begin
                    flag_clr = 1'b1;
                    exp_fast = 1'b0;
                    exp_slow = 1'b0;
                end
            end
            if (j == 11) flag_clr = 1'b0;
            if (j == 13 && do_clr) chk("R10 cleared", {30'd0, too_fast, too_slow}, 32'd0);
        end
        prev_exp   = clamp16(mode ? nev : p);
        prev_tag   = mode ? "R9 event count" : ((p > 65535) ? "R12 saturation" : "R6 cycle count");
        prev_valid = 1'b1;
        prev_lo    = lo;
        prev_hi    = hi;
    endtask

    task automatic loss_phase(input bit stuck_high);
        int base;
        min_w = 1.0e9;
        if (stuck_high) @(posedge sys_clk);
        else            @(negedge sys_clk);
        pw_en = 1'b1;
        sys_run = 1'b0;
        #30;
        chk("R2 not before quiet count", 32'(clk_fail), 32'd0);
        repeat (40) @(negedge bak_clk);
        chk(stuck_high ? "R5 fail stuck high" : "R2 fail raised", 32'(clk_fail), 32'd1);
        base = clk_edges;
        repeat (40) @(negedge bak_clk);
        chk(stuck_high ? "R5 backup edges" : "R3 backup edges", 32'(clk_edges - base), 32'd40);
        pw_en = 1'b0;
        n_run++;
        if (min_w < 6.9) begin
            n_fail++;
            $display("FAIL R4 pulse width: actual=%0f expected>=7.0", min_w);
        end
    endtask

    initial begin
        #4000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog (R1..all): actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed_v;
        int base;
        seed_v = int'($urandom(32'd2024));
        // R1: reset state
        repeat (5) @(negedge sys_clk);
        chk("R1 clk_o low in reset", 32'(clk_o), 32'd0);
        chk("R1 outputs in reset", {13'd0, clk_fail, too_fast, too_slow, win_count}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge sys_clk);
        base = clk_edges;
        repeat (50) @(negedge sys_clk);
        chk("R1 clk_o follows system", 32'(clk_edges - base), 32'd50);
        chk("R1 no fail while running", 32'(clk_fail), 32'd0);

        // directed windows
        run_window(30, 0, 1'b0, 16'd0, 16'hFFFF, 1'b0);   // R11 check happens here
        run_window(40, 0, 1'b0, 16'd10, 16'd35, 1'b0);
        run_window(25, 0, 1'b0, 16'd10, 16'd35, 1'b1);     // 40 judged fast, then cleared
        run_window(20, 0, 1'b0, 16'd22, 16'd35, 1'b0);
        run_window(22, 0, 1'b0, 16'd22, 16'd22, 1'b1);     // 20 judged slow; 22 on both limits
        run_window(60, 7, 1'b1, 16'd5, 16'd9, 1'b1);
        run_window(60, 3, 1'b1, 16'd5, 16'd9, 1'b1);
        run_window(60, 12, 1'b1, 16'd5, 16'd9, 1'b1);
        run_window(40, 9, 1'b1, 16'd9, 16'd9, 1'b1);

        // seeded random windows
        for (int k = 0; k < 30; k++) begin
            int p, nev, e, lo_i, hi_i;
            bit m, c;
            p    = 16 + int'($urandom_range(0, 64));
            m    = 1'($urandom_range(0, 1));
            nev  = int'($urandom_range(0, (p - 2) / 4));
            e    = m ? nev : p;
            lo_i = e + int'($urandom_range(0, 10)) - 5;
            if (lo_i < 0) lo_i = 0;
            hi_i = lo_i + int'($urandom_range(0, 8));
            c    = ($urandom_range(0, 3) == 0);
            run_window(p, nev, m, 16'(lo_i), 16'(hi_i), c);
        end

        // R12: saturation
        run_window(66000, 0, 1'b0, 16'd0, 16'hFFFE, 1'b1);
        run_window(20, 0, 1'b0, 16'd0, 16'hFFFF, 1'b1);
        run_window(20, 0, 1'b0, 16'd0, 16'hFFFF, 1'b0);

        // loss with clock stopped low
        loss_phase(1'b0);
        sys_run = 1'b1;
        base = clk_edges;
        repeat (40) @(negedge bak_clk);
        chk("R3 failover holds after restart", 32'(clk_edges - base), 32'd40);
        chk("R3 fail held", 32'(clk_fail), 32'd1);

        // reset returns to the system clock
        rst_n = 1'b0;
        repeat (4) @(negedge sys_clk);
        chk("R1 fail cleared by reset", 32'(clk_fail), 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge sys_clk);
        base = clk_edges;
        repeat (50) @(negedge sys_clk);
        chk("R1 clk_o follows system again", 32'(clk_edges - base), 32'd50);

        // loss with clock stuck high: forced close
        loss_phase(1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule